// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block produces the four condition flags N, Z, V and C of an integer datapath after the fact, and only when something needs them. The datapath does not send the adder's carry and overflow wires. Instead it keeps three values: a tag naming the last flag-setting operation and its operand size, the result it produced, and the source operand it used. When a consumer needs the flags, a one-cycle flush strobe presents these three values to the block. One clock later the block has rebuilt the flags and holds them in a register.

The flags are rebuilt from the result and the source alone. For each operation class the block first recovers the original destination operand with the inverse operation. It then derives carry from an unsigned comparison at the chosen width and overflow from the sign bits of the three operands. Operations with extend (carry-in of one) use an inclusive comparison for carry. Byte, word and long widths are supported, so any bits above the selected width do not affect any flag.

Top module: `lazy_flag_eval`

## Requirements
- R1: While `rst_n` is low, `flags_o` is cleared to 4'b0000. The flags are still 4'b0000 in the first cycle after reset is released.
- R2: `tag_i[4:2]` selects the class: 0 direct flags, 1 logic, 2 add, 3 subtract, 4 add-with-extend, 5 subtract-with-extend. `tag_i[1:0]` selects the size: 0 byte, 1 word, 2 long. `flags_o` is {N,Z,V,C} from bit 3 down to bit 0. `flags_o` changes only on the clock edge at which `flush_i` is sampled high, and otherwise holds its value.
- R3: Direct-flags class: `flags_o` takes `dst_i[3:0]` unchanged, whatever the size field holds.
- R4: Logic class: N is the size's sign bit of the result (bit 7, 15 or 31), Z is set when all result bits within the size are zero, and V and C are cleared. N and Z are never both set by any class except direct flags.
- R5: Add class: C is set when the result is unsigned-below the source. V is set when the signed sum of the recovered destination (result minus source) and the source falls outside the signed range of the size.
- R6: Add-with-extend class: C is set when the result is unsigned at most the source. The destination is recovered as result minus source minus one. V marks signed overflow of destination plus source plus one.
- R7: Subtract class: the destination is recovered as result plus source. C is set when that destination is unsigned-below the source. V marks signed overflow of destination minus source.
- R8: Subtract-with-extend class: the destination is recovered as result plus source plus one. C is set when that destination is unsigned at most the source. V marks signed overflow of destination minus source minus one.
- R9: For byte size, bits 31..8 of both `dst_i` and `src_i` affect no flag. For word size, bits 31..16 affect no flag.
- R10: A flush with class 6 or 7, or with size 3 in any class other than direct flags, leaves `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Evaluate the presented state this cycle |
| tag_i | input | 5 | Operation class in [4:2] and operand size in [1:0] |
| dst_i | input | 32 | Stored result, or raw flags for the direct class |
| src_i | input | 32 | Stored source operand |
| flags_o | output | 4 | Registered {N,Z,V,C} |

## Verification
The bench picks operand pairs whose true sums and differences sit exactly on the unsigned and signed wrap points of each width. Examples are 0x7F plus 1, 0x80 minus 1, 0 minus 0 with extend, and all-ones plus one with extend. A design that used a strict comparison for an extend class would miss the carry in the equality cases. A design that took the sign bit from a fixed position, or compared untruncated values, would report wrong N, V or C once junk bits are placed above a byte or word operand. Flushes with reserved tags and cycles without a flush check that a sloppy decode neither clobbers nor drifts the held flags.

// File: rtl/lazy_flag_eval.sv
module lazy_flag_eval (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_i,
  input  logic [4:0]  tag_i,
  input  logic [31:0] dst_i,
  input  logic [31:0] src_i,
  output logic [3:0]  flags_o
);

  localparam logic [2:0] K_FLAGS = 3'd0;
  localparam logic [2:0] K_LOGIC = 3'd1;
  localparam logic [2:0] K_ADD   = 3'd2;
  localparam logic [2:0] K_SUB   = 3'd3;
  localparam logic [2:0] K_ADDX  = 3'd4;
  localparam logic [2:0] K_SUBX  = 3'd5;

  logic [2:0]  kind;
  logic [1:0]  size;
  logic [31:0] mask, rm, sm, orig, ovf;
  logic [4:0]  top;
  logic        neg, zero, carry, valid;
  logic [3:0]  next_flags;

  assign kind = tag_i[4:2];
  assign size = tag_i[1:0];

  always_comb begin
    case (size)
      2'd0:    begin mask = 32'h0000_00ff; top = 5'd7;  end
      2'd1:    begin mask = 32'h0000_ffff; top = 5'd15; end
      default: begin mask = 32'hffff_ffff; top = 5'd31; end
    endcase
  end

  assign rm   = dst_i & mask;
  assign sm   = src_i & mask;
  assign neg  = rm[top];
  assign zero = (rm == 32'd0);

  always_comb begin
    orig  = 32'd0;
    carry = 1'b0;
    ovf   = 32'd0;
    case (kind)
      K_ADD: begin
        orig  = (rm - sm) & mask;
        carry = rm < sm;
        ovf   = (sm ^ rm) & ~(orig ^ sm);
      end
      K_ADDX: begin
        orig  = (rm - sm - 32'd1) & mask;
        carry = rm <= sm;
        ovf   = (sm ^ rm) & ~(orig ^ sm);
      end
      K_SUB: begin
        orig  = (rm + sm) & mask;
        carry = orig < sm;
        ovf   = (orig ^ rm) & (orig ^ sm);
      end
      K_SUBX: begin
        orig  = (rm + sm + 32'd1) & mask;
        carry = orig <= sm;
        ovf   = (orig ^ rm) & (orig ^ sm);
      end
      default: ;
    endcase
  end

  always_comb begin
    valid      = (size != 2'd3);
    next_flags = {neg, zero, ovf[top], carry};
    case (kind)
      K_FLAGS: begin valid = 1'b1; next_flags = dst_i[3:0]; end
      K_LOGIC: next_flags = {neg, zero, 2'b00};
      K_ADD, K_SUB, K_ADDX, K_SUBX: ;
      default: valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags_o <= 4'b0000;
    else if (flush_i && valid)
      flags_o <= next_flags;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> flags_o == 4'b0000);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |=> $stable(flags_o));

  assert_direct_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && kind == K_FLAGS) |=> flags_o == $past(dst_i[3:0]));

  assert_logic_vc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && kind == K_LOGIC && size != 2'd3) |=> flags_o[1:0] == 2'b00);

  assert_nz_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && kind != K_FLAGS) |=> !(flags_o[3] && flags_o[2]));

  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && (kind > K_SUBX || (kind != K_FLAGS && size == 2'd3))) |=> $stable(flags_o));

endmodule

// File: tb/lazy_flag_eval_tb_top.sv
module lazy_flag_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [4:0]  tag_i = 5'd0;
  logic [31:0] dst_i = 32'd0;
  logic [31:0] src_i = 32'd0;
  logic [3:0]  flags_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lazy_flag_eval dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .tag_i(tag_i),
    .dst_i(dst_i), .src_i(src_i), .flags_o(flags_o)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_cmp++;
    if (flags_o !== exp) begin
      n_bad++;
      $display("FAIL %s: flags actual %b expected %b", req, flags_o, exp);
    end
  endtask

  task automatic flush(input logic [4:0] tag, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    tag_i = tag; dst_i = d; src_i = s; flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  // Operand-level reference: cls 2 add, 3 sub, 4 addx, 5 subx.
  task automatic arith(input string req, input int cls, input int sz,
                       input longint a, input longint b, input logic [31:0] junk);
    longint m, am, bm, sa, sb, full, sv, r;
    logic n, z, v, c;
    logic [31:0] hi, dd, ss;
    m  = (sz == 0) ? 64'h100 : (sz == 1) ? 64'h10000 : 64'h1_0000_0000;
    am = a % m; bm = b % m;
    sa = (am >= m/2) ? am - m : am;
    sb = (bm >= m/2) ? bm - m : bm;
    case (cls)
      2: begin full = am + bm;     sv = sa + sb;     c = full >= m; end
      4: begin full = am + bm + 1; sv = sa + sb + 1; c = full >= m; end
      3: begin full = am - bm;     sv = sa - sb;     c = am < bm;   end
      default: begin full = am - bm - 1; sv = sa - sb - 1; c = am <= bm; end
    endcase
    r  = ((full % m) + m) % m;
    v  = (sv >= m/2) || (sv < -(m/2));
    n  = r >= m/2;
    z  = r == 0;
    hi = (sz == 2) ? 32'd0 : ~32'(m - 1);
    dd = 32'(r) | (junk & hi);
    ss = 32'(bm) | (~junk & hi);
    flush({3'(cls), 2'(sz)}, dd, ss);
    check(req, {n, z, v, c});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'b0000);
  endtask

  task automatic t_direct();
    flush({3'd0, 2'd2}, 32'hffff_fff5, 32'h0);
    check("R3", 4'b0101);
    flush({3'd0, 2'd3}, 32'h0000_000a, 32'hffff_ffff);
    check("R3", 4'b1010);
  endtask

  task automatic t_logic();
    flush({3'd1, 2'd0}, 32'h1234_5680, 32'h0);
    check("R4 byte neg", 4'b1000);
    flush({3'd1, 2'd1}, 32'hffff_0000, 32'h0);
    check("R4 word zero", 4'b0100);
    flush({3'd1, 2'd2}, 32'h7fff_ffff, 32'hffff_ffff);
    check("R4 long pos", 4'b0000);
  endtask

  task automatic t_add();
    arith("R5 byte signed wrap", 2, 0, 64'h7f, 64'h01, 32'h0);
    arith("R5 byte carry", 2, 0, 64'hff, 64'h01, 32'h0);
    arith("R5 word neg+neg", 2, 1, 64'h8000, 64'h8000, 32'h0);
    arith("R5 long", 2, 2, 64'h7fff_ffff, 64'h7fff_ffff, 32'h0);
    arith("R5 long carry", 2, 2, 64'hffff_fff0, 64'h20, 32'h0);
  endtask

  task automatic t_addx();
    arith("R6 byte ones+0+1", 4, 0, 64'hff, 64'h00, 32'h0);
    arith("R6 byte eq carry", 4, 0, 64'hff, 64'hff, 32'h0);
    arith("R6 word signed", 4, 1, 64'h7fff, 64'h0000, 32'h0);
    arith("R6 long", 4, 2, 64'h1234, 64'h5678, 32'h0);
  endtask

  task automatic t_sub();
    arith("R7 byte borrow", 3, 0, 64'h00, 64'h01, 32'h0);
    arith("R7 byte signed", 3, 0, 64'h80, 64'h01, 32'h0);
    arith("R7 word equal", 3, 1, 64'h1234, 64'h1234, 32'h0);
    arith("R7 long signed", 3, 2, 64'h7fff_ffff, 64'hffff_ffff, 32'h0);
  endtask

  task automatic t_subx();
    arith("R8 byte 0-0-1", 5, 0, 64'h00, 64'h00, 32'h0);
    arith("R8 byte signed", 5, 0, 64'h80, 64'h00, 32'h0);
    arith("R8 word eq", 5, 1, 64'h4000, 64'h4000, 32'h0);
    arith("R8 long", 5, 2, 64'h10, 64'h3, 32'h0);
  endtask

  task automatic t_trunc();
    arith("R9 add byte junk", 2, 0, 64'h7f, 64'h01, 32'ha5a5_a5a5);
    arith("R9 sub byte junk", 3, 0, 64'h00, 64'h01, 32'h5a5a_5a5a);
    arith("R9 addx word junk", 4, 1, 64'hffff, 64'h0000, 32'hdead_beef);
    arith("R9 subx word junk", 5, 1, 64'h8000, 64'h0000, 32'h1357_9bdf);
    flush({3'd1, 2'd0}, 32'hffff_ff00, 32'h0);
    check("R9 logic byte junk", 4'b0100);
  endtask

  task automatic t_hold();
    flush({3'd0, 2'd0}, 32'h0000_0009, 32'h0);
    check("R2 setup", 4'b1001);
    @(negedge clk);
    tag_i = {3'd0, 2'd0}; dst_i = 32'h6; src_i = 32'h0;
    repeat (3) @(negedge clk);
    check("R2 no flush", 4'b1001);
    flush({3'd6, 2'd0}, 32'h0, 32'h0);
    check("R10 class 6", 4'b1001);
    flush({3'd7, 2'd2}, 32'h0, 32'h0);
    check("R10 class 7", 4'b1001);
    flush({3'd2, 2'd3}, 32'h0, 32'h1);
    check("R10 size 3", 4'b1001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_direct();
    t_logic();
    t_add();
    t_addx();
    t_sub();
    t_subx();
    t_trunc();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule